// File: doc/BRIEF.md
# Circular Sampling Window Centre Finder

This block picks a receive sampling phase by trial. After a start request it walks a phase selector through twelve evenly spaced points (30 degrees apart, a full turn), raising a one-cycle launch strobe for each point and waiting for an external tester to report completion and a pass or fail verdict. The verdicts build a twelve-bit pass map, bit k holding the verdict for point k.

Once all twelve points are tried, the block treats the map as a ring. Every-point-passes gives point 0; no-point-passes is a failure. Otherwise the map is rotated right by the position of the lowest failing point, so no run of passes crosses the ring's seam. The rotated map is scanned one bit per clock to find the longest run of passes, the earliest run winning a tie. The chosen point is the run's first position plus half its length (rounded down), with the rotation added back modulo twelve. The result drives the phase output and is flagged by a one-cycle completion pulse and a success flag.

Top module: `phase_window_tuner`

## Requirements
- R1: After reset the phase output is 0 and the launch strobe, busy, completion pulse and success flag are all low.
- R2: A sweep issues exactly twelve one-cycle launch strobes with the phase output at 0, 1, ..., 11 in that order; the phase holds while a trial is outstanding and the next launch waits for the tester's completion flag.
- R3: When all twelve points pass, the result is point 0 with the success flag high.
- R4: When no point passes, the success flag is low and the phase output stays at 11, the last point tried.
- R5: For a window that does not cross the seam, the result is the window's first point plus half its length rounded down.
- R6: A window that crosses from point 11 to point 0 is treated as one contiguous run, and the result is reduced modulo 12.
- R7: Among equally long runs, the one starting earliest after rotating the map right by the lowest failing index is chosen.
- R8: A start request made while a sweep or search is in progress is ignored: the sweep still issues twelve launches and gives the same result.
- R9: The completion pulse lasts one cycle, busy is low in that cycle, and the phase output already shows the result then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new sweep; sampled while idle |
| trial_done_i | input | 1 | Tester reports the current trial finished |
| trial_pass_i | input | 1 | Verdict of the current trial, valid with trial_done_i |
| phase_o | output | 4 | Selected sampling point index (0 to 11) |
| trial_start_o | output | 1 | One-cycle launch of a trial at phase_o |
| busy_o | output | 1 | Sweep or search in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| ok_o | output | 1 | Result valid (1) or tuning failed (0) |

## Verification
The bench builds the block with its default of twelve points, which keeps every pass map small enough to work out the expected centre by hand. That puts the all-pass and all-fail cases, windows that straddle the seam between points 11 and 0, ties between equal runs, even and odd window lengths and a single failing point all within one short table. Directed runs add the reset state and start requests made during the sweep and during the search.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_EVAL,
        ST_SCAN,
        ST_CENTER
    } tune_state_t;
endpackage

// File: rtl/ring_rotator.sv
module ring_rotator #(
    parameter int WIDTH = 12,
    parameter int SEL_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec_i,
    input  logic [SEL_W-1:0] amount_i,
    output logic [WIDTH-1:0] vec_o
);
    function automatic logic pick(input logic [WIDTH-1:0] v, input int pos, input logic [SEL_W-1:0] amt);
        logic r;
        r = 1'b0;
        for (int j = 0; j < WIDTH; j++) begin
            if (int'(amt) == j) r = v[(pos + j) % WIDTH];
        end
        return r;
    endfunction

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        assign vec_o[g] = pick(vec_i, g, amount_i);
    end
endmodule

// File: rtl/lowest_zero_finder.sv
module lowest_zero_finder #(
    parameter int WIDTH = 12,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             all_ones_o,
    output logic             all_zero_o
);
    always_comb begin
        idx_o = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (!vec_i[i]) idx_o = IDX_W'(i);
        end
        all_ones_o = &vec_i;
        all_zero_o = ~|vec_i;
    end
endmodule

// File: rtl/phase_window_tuner.sv
module phase_window_tuner #(
    parameter int NUM_POINTS = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          trial_done_i,
    input  logic                          trial_pass_i,
    output logic [$clog2(NUM_POINTS)-1:0] phase_o,
    output logic                          trial_start_o,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          ok_o
);
    import phase_tune_pkg::*;

    localparam int IDX_W = $clog2(NUM_POINTS);
    localparam int LEN_W = $clog2(NUM_POINTS + 1);
    localparam int SUM_W = $clog2(2 * NUM_POINTS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_POINTS - 1);

    typedef struct packed {
        tune_state_t             st;
        logic [IDX_W-1:0]        phase;
        logic [NUM_POINTS-1:0]   map;
        logic [NUM_POINTS-1:0]   rot;
        logic [IDX_W-1:0]        shift;
        logic [IDX_W-1:0]        pos;
        logic [LEN_W-1:0]        cur_len;
        logic [LEN_W-1:0]        best_len;
        logic [IDX_W-1:0]        best_start;
        logic                    done;
        logic                    ok;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_POINTS-1:0] rot_w;
    logic [IDX_W-1:0]      first_fail_w;
    logic                  all_pass_w;
    logic                  all_fail_w;

    ring_rotator #(.WIDTH(NUM_POINTS), .SEL_W(IDX_W)) u_rot (
        .vec_i    (r_q.map),
        .amount_i (first_fail_w),
        .vec_o    (rot_w)
    );

    lowest_zero_finder #(.WIDTH(NUM_POINTS), .IDX_W(IDX_W)) u_fz (
        .vec_i      (r_q.map),
        .idx_o      (first_fail_w),
        .all_ones_o (all_pass_w),
        .all_zero_o (all_fail_w)
    );

    always_comb begin
        logic [LEN_W-1:0] run_len;
        logic [SUM_W-1:0] sum;
        r_d      = r_q;
        r_d.done = 1'b0;
        run_len  = r_q.cur_len + LEN_W'(1);
        sum      = SUM_W'(r_q.best_start) + SUM_W'(r_q.best_len >> 1) + SUM_W'(r_q.shift);
        if (sum >= SUM_W'(NUM_POINTS)) sum = sum - SUM_W'(NUM_POINTS);
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_LAUNCH;
                    r_d.phase = '0;
                    r_d.map   = '0;
                end
            end
            ST_LAUNCH: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (trial_done_i) begin
                    r_d.map[r_q.phase] = trial_pass_i;
                    if (r_q.phase == LAST_IDX) begin
                        r_d.st = ST_EVAL;
                    end else begin
                        r_d.phase = r_q.phase + IDX_W'(1);
                        r_d.st    = ST_LAUNCH;
                    end
                end
            end
            ST_EVAL: begin
                if (all_pass_w) begin
                    r_d.phase = '0;
                    r_d.ok    = 1'b1;
                    r_d.done  = 1'b1;
                    r_d.st    = ST_IDLE;
                end else if (all_fail_w) begin
                    r_d.ok   = 1'b0;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.rot        = rot_w;
                    r_d.shift      = first_fail_w;
                    r_d.pos        = '0;
                    r_d.cur_len    = '0;
                    r_d.best_len   = '0;
                    r_d.best_start = '0;
                    r_d.st         = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (r_q.rot[r_q.pos]) begin
                    r_d.cur_len = run_len;
                    if (run_len > r_q.best_len) begin
                        r_d.best_len   = run_len;
                        r_d.best_start = IDX_W'(SUM_W'(r_q.pos) - SUM_W'(r_q.cur_len));
                    end
                end else begin
                    r_d.cur_len = '0;
                end
                if (r_q.pos == LAST_IDX) r_d.st = ST_CENTER;
                else r_d.pos = r_q.pos + IDX_W'(1);
            end
            ST_CENTER: begin
                r_d.phase = IDX_W'(sum);
                r_d.ok    = 1'b1;
                r_d.done  = 1'b1;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign phase_o       = r_q.phase;
    assign trial_start_o = (r_q.st == ST_LAUNCH);
    assign busy_o        = (r_q.st != ST_IDLE);
    assign done_o        = r_q.done;
    assign ok_o          = r_q.ok;
endmodule

// File: rtl/phase_window_tuner_chk.sv
module phase_window_tuner_chk #(
    parameter int NUM_POINTS = 12
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          start_i,
    input logic                          trial_done_i,
    input logic [$clog2(NUM_POINTS)-1:0] phase_o,
    input logic                          trial_start_o,
    input logic                          busy_o,
    input logic                          done_o,
    input logic                          ok_o
);
    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r2_launch_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        trial_start_o |=> !trial_start_o);

    a_r2_phase_held_in_trial: assert property (@(posedge clk) disable iff (!rst_n)
        trial_start_o |=> $stable(phase_o));

    a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase_o) < NUM_POINTS);

    a_r2_launch_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !trial_start_o && !trial_done_i) |=> !trial_start_o);

    a_r1_no_launch_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !trial_start_o);

    a_r8_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !trial_start_o && !trial_done_i) |=> !trial_start_o);

    a_r4_fail_keeps_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ok_o) |-> $stable(phase_o));
endmodule

bind phase_window_tuner phase_window_tuner_chk #(.NUM_POINTS(NUM_POINTS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .trial_done_i  (trial_done_i),
    .phase_o       (phase_o),
    .trial_start_o (trial_start_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .ok_o          (ok_o)
);

// File: tb/phase_window_tuner_tb.sv
module phase_window_tuner_tb;
    localparam int NP = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       trial_done_i = 1'b0;
    logic       trial_pass_i = 1'b0;
    logic [3:0] phase_o;
    logic       trial_start_o, busy_o, done_o, ok_o;

    int total = 0;
    int bad = 0;
    int launches = 0;
    longint cycles = 0;

    always #5 clk = ~clk;

    phase_window_tuner #(.NUM_POINTS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .trial_done_i(trial_done_i), .trial_pass_i(trial_pass_i),
        .phase_o(phase_o), .trial_start_o(trial_start_o),
        .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o)
    );

    always @(negedge clk) if (trial_start_o) launches++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    typedef struct packed {
        logic [11:0] map;
        logic [3:0]  idx;
        logic        ok;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{12'hFFF, 4'd0,  1'b1, 4'd3},  // R3 all pass
        '{12'h000, 4'd11, 1'b0, 4'd4},  // R4 all fail
        '{12'h001, 4'd0,  1'b1, 4'd6},  // R6 single point 0
        '{12'h0F0, 4'd6,  1'b1, 4'd5},  // R5 window 4..7
        '{12'hE03, 4'd11, 1'b1, 4'd6},  // R6 window 9..1 wraps
        '{12'h066, 4'd2,  1'b1, 4'd7},  // R7 tie 1..2 vs 5..6
        '{12'h800, 4'd11, 1'b1, 4'd5},  // R5 single point 11
        '{12'hFDF, 4'd11, 1'b1, 4'd6},  // R6 only point 5 fails
        '{12'h839, 4'd4,  1'b1, 4'd6},  // R6 longer inner run beats wrap
        '{12'h03C, 4'd4,  1'b1, 4'd5},  // R5 even length 2..5
        '{12'h01C, 4'd3,  1'b1, 4'd5},  // R5 odd length 2..4
        '{12'h041, 4'd6,  1'b1, 4'd7}   // R7 tie in rotated frame
    };

    task automatic check(input bit cond, input string req, input string what, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic sweep(input logic [11:0] map, input bit inject, output int res_idx, output int res_ok);
        int n;
        launches = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int k = 0; k < NP; k++) begin
            n = 0;
            while (!trial_start_o && n < 50) begin @(negedge clk); n++; end
            check(trial_start_o && int'(phase_o) == k, "R2", "launch phase", int'(phase_o), k);
            if (inject && k == 3) start_i = 1'b1;   // R8 request mid-sweep
            @(negedge clk); start_i = 1'b0;
            @(negedge clk);
            trial_done_i = 1'b1; trial_pass_i = map[k];
            @(negedge clk);
            trial_done_i = 1'b0; trial_pass_i = 1'b0;
        end
        if (inject) begin start_i = 1'b1; @(negedge clk); start_i = 1'b0; end  // R8 during search
        n = 0;
        while (!done_o && n < 100) begin @(negedge clk); n++; end
        check(done_o && !busy_o, "R9", "done with busy low", int'(done_o), 1);
        res_idx = int'(phase_o);
        res_ok  = int'(ok_o);
        @(negedge clk);
        check(!done_o, "R9", "done one cycle", int'(done_o), 0);
        check(launches == NP, "R2", "launch count", launches, NP);
    endtask

    initial begin
        int idx, ok;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(phase_o == 0 && !trial_start_o && !busy_o && !done_o && !ok_o,
              "R1", "reset outputs", int'({phase_o, trial_start_o, busy_o, done_o, ok_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy_o && !trial_start_o, "R1", "idle after reset", int'(busy_o), 0);

        for (int v = 0; v < 12; v++) begin
            sweep(VECS[v].map, 1'b0, idx, ok);
            total++;
            if (idx != int'(VECS[v].idx) || ok != int'(VECS[v].ok)) begin
                bad++;
                $display("FAIL R%0d vector %0d map=%03h: actual idx=%0d ok=%0d expected idx=%0d ok=%0d",
                         VECS[v].req, v, VECS[v].map, idx, ok, VECS[v].idx, VECS[v].ok);
            end
        end

        // R8 start requests while busy are ignored
        sweep(12'h0F0, 1'b1, idx, ok);
        check(idx == 6 && ok == 1, "R8", "result with extra starts", idx, 6);
        repeat (5) @(negedge clk);
        check(!busy_o && !trial_start_o, "R8", "no restart after ignored start", int'(busy_o), 0);

        // R4 failure after a success leaves phase at last trial
        sweep(12'h000, 1'b0, idx, ok);
        check(idx == 11 && ok == 0, "R4", "fail after success", idx, 11);

        // R3 all pass after a failure
        sweep(12'hFFF, 1'b0, idx, ok);
        check(idx == 0 && ok == 1, "R3", "all pass recovers", idx, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule